// File: doc/BRIEF.md
# TDM Audio Frame-Sync Generator

This block produces, or receives, the frame-sync for a multichannel time-division audio transmitter. It runs on the bit clock. In internal mode it counts bit clocks within a slot word and slots within a frame. It drives a sync strobe of programmable width and polarity, and it marks the first bit of every frame with a start-of-frame flag toward the serializer. In external mode the internal counters stay idle. The sync pin is resynchronized, and the flag is raised when the chosen edge arrives.

The slot count, the pulse width, the polarity and the source select are held in a shadow copy. While the block runs, the shadow copy is refreshed only at a frame boundary, so a frame already in progress is never reshaped. A separate direction input decides whether the sync leaves the chip. The pin enable stays low until that input is set, and it is always low in external mode. Software sets up the frame fields first and the direction last. A standard two-channel serial audio link uses a slot count of 2.

Top module: `tdm_fsync_gen`

## Requirements
- R1: In internal mode with enable high, a frame lasts S x WORD_LEN bit clocks, where S is the shadowed slot count and may be any value from 2 to 32. `sof` is high for exactly the first bit clock of each frame.
- R2: A slot setting below 2 acts as 2, and a setting above 32 acts as 32.
- R3: With `cfg_wide`=1 the pulse is active for the WORD_LEN bit clocks of slot 0. With `cfg_wide`=0 it is active only for bit 0 of slot 0.
- R4: With `cfg_fall`=0 the active level is 1 and the idle level is 0, so a frame begins on a rising edge. With `cfg_fall`=1 the active level is 0 and the idle level is 1, so a frame begins on a falling edge. While enable is low, a driven pin shows the idle level.
- R5: While enable is low, the counters return to the start of a frame. Suppose enable is sampled high at a clock edge after a low cycle. Then in the cycle that follows that edge, the pulse is active and `sof` is high.
- R6: In external mode (`cfg_internal`=0) with enable high, the pin passes through a two-stage synchronizer. Suppose the configured edge arrives on `fs_in` before clock edge k. Then `sof` is high only in the cycle between edges k+1 and k+2. The opposite edge never raises `sof`.
- R7: `fs_oe` equals `pin_dir_out` AND the shadowed internal-source bit. `fs_out` is 0 whenever `fs_oe` is 0.
- R8: While a frame is running, changes to the slot count, width, polarity or source take effect only at the next frame boundary. While enable is low they are taken at once.
- R9: While `rst_n` is low, and until configuration after release, `fs_oe`, `fs_out` and `sof` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run frame generation or detection |
| cfg_slots | input | 6 | Slots per frame (clamped to 2..32) |
| cfg_wide | input | 1 | 1: pulse one slot word, 0: one bit clock |
| cfg_fall | input | 1 | 1: frame starts on falling edge (active low) |
| cfg_internal | input | 1 | 1: internal sync, 0: sync from pin |
| pin_dir_out | input | 1 | Direction control, 1 lets the pin be driven |
| fs_in | input | 1 | Sync pin input value |
| fs_out | output | 1 | Sync pin output value |
| fs_oe | output | 1 | Sync pin output enable |
| sof | output | 1 | Start-of-frame flag to the serializer |

## Verification
The assertions assume that `enable`, the configuration inputs and `pin_dir_out` are synchronous to the bit clock, and that `WORD_LEN` is at least 2. Together these make an internal start-of-frame last a single cycle. They also assume that `fs_in` holds each level long enough to pass through the synchronizer. The stimulus changes every input only on the falling clock edge. It holds each pin level for several cycles in external mode. It changes configuration mid-frame only in the test that is aimed at boundary-only updates.

// File: rtl/tdm_fsync_pkg.sv
package tdm_fsync_pkg;
  localparam int MIN_SLOTS = 2;
  localparam int MAX_SLOTS = 32;
  localparam int SLOT_W    = $clog2(MAX_SLOTS + 1);

  typedef struct packed {
    logic [SLOT_W-1:0] slots;
    logic              wide;
    logic              fall;
    logic              internal;
  } fs_cfg_t;
endpackage

// File: rtl/tdm_fsync_shadow.sv
module tdm_fsync_shadow
  import tdm_fsync_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load_en,
  input  fs_cfg_t cfg_in,
  output fs_cfg_t cfg_q
);
  fs_cfg_t           cfg_d;
  logic [SLOT_W-1:0] slots_clamped;

  always_comb begin
    slots_clamped = cfg_in.slots;
    if (cfg_in.slots < SLOT_W'(MIN_SLOTS)) slots_clamped = SLOT_W'(MIN_SLOTS);
    if (cfg_in.slots > SLOT_W'(MAX_SLOTS)) slots_clamped = SLOT_W'(MAX_SLOTS);
  end

  always_comb begin
    cfg_d = cfg_q;
    if (load_en) begin
      cfg_d       = cfg_in;
      cfg_d.slots = slots_clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.slots    <= SLOT_W'(MIN_SLOTS);
      cfg_q.wide     <= 1'b0;
      cfg_q.fall     <= 1'b0;
      cfg_q.internal <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/tdm_fsync_count.sv
module tdm_fsync_count
  import tdm_fsync_pkg::*;
#(
  parameter int WORD_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_req,
  input  logic [SLOT_W-1:0] slots,
  input  logic              wide,
  output logic              run_q,
  output logic              sof_int,
  output logic              pulse,
  output logic              frame_last
);
  localparam int             BIT_W    = $clog2(WORD_LEN);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_LEN - 1);

  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              run_d;
  logic              bit_wrap, slot_wrap;

  assign bit_wrap   = (bit_q == BIT_LAST);
  assign slot_wrap  = (slot_q == slots - SLOT_W'(1));
  assign frame_last = run_q && bit_wrap && slot_wrap;
  assign sof_int    = run_q && (bit_q == '0) && (slot_q == '0);
  assign pulse      = run_q && (slot_q == '0) && (wide || (bit_q == '0));

  always_comb begin
    run_d  = run_req;
    bit_d  = '0;
    slot_d = '0;
    if (run_req && run_q) begin
      if (bit_wrap) begin
        bit_d  = '0;
        slot_d = slot_wrap ? '0 : slot_q + SLOT_W'(1);
      end else begin
        bit_d  = bit_q + BIT_W'(1);
        slot_d = slot_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      bit_q  <= '0;
      slot_q <= '0;
    end else begin
      run_q  <= run_d;
      bit_q  <= bit_d;
      slot_q <= slot_d;
    end
  end
endmodule

// File: rtl/tdm_fsync_edge.sv
module tdm_fsync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_in};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] && !prev_q;
  assign fall = !sync_q[SYNC_STAGES-1] && prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/tdm_fsync_gen.sv
module tdm_fsync_gen
  import tdm_fsync_pkg::*;
#(
  parameter int WORD_LEN    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [SLOT_W-1:0] cfg_slots,
  input  logic              cfg_wide,
  input  logic              cfg_fall,
  input  logic              cfg_internal,
  input  logic              pin_dir_out,
  input  logic              fs_in,
  output logic              fs_out,
  output logic              fs_oe,
  output logic              sof
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  fs_cfg_t    cfg_in, sh_q;
  logic       load_en, run_req, run_q;
  logic       sof_int, pulse, frame_last;
  logic       pin_rise, pin_fall, ext_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  always_comb begin
    cfg_in.slots    = cfg_slots;
    cfg_in.wide     = cfg_wide;
    cfg_in.fall     = cfg_fall;
    cfg_in.internal = cfg_internal;
  end

  assign ext_edge = enable && !sh_q.internal && (sh_q.fall ? pin_fall : pin_rise);
  assign load_en  = !enable || (sh_q.internal ? (!run_q || frame_last) : ext_edge);
  assign run_req  = enable && (load_en ? cfg_internal : sh_q.internal);

  tdm_fsync_shadow u_shadow (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_en (load_en),
    .cfg_in  (cfg_in),
    .cfg_q   (sh_q)
  );

  tdm_fsync_count #(.WORD_LEN(WORD_LEN)) u_count (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .run_req    (run_req),
    .slots      (sh_q.slots),
    .wide       (sh_q.wide),
    .run_q      (run_q),
    .sof_int    (sof_int),
    .pulse      (pulse),
    .frame_last (frame_last)
  );

  tdm_fsync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_in (fs_in),
    .rise   (pin_rise),
    .fall   (pin_fall)
  );

  assign sof    = sh_q.internal ? sof_int : ext_edge;
  assign fs_oe  = pin_dir_out && sh_q.internal;
  assign fs_out = fs_oe && (pulse ^ sh_q.fall);
endmodule

// File: rtl/tdm_fsync_chk.sv
module tdm_fsync_chk
  import tdm_fsync_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pin_dir_out,
  input logic              fs_out,
  input logic              fs_oe,
  input logic              sof,
  input logic              run_q,
  input logic              sh_internal,
  input logic              sh_fall,
  input logic              sh_wide,
  input logic [SLOT_W-1:0] sh_slots
);
  // R7: with the direction control cleared, the pin is neither enabled nor driven high
  p_pin_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_dir_out |-> (!fs_oe && !fs_out));

  // R7: the pin is never enabled in external mode
  p_ext_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_internal |-> !fs_oe);

  // R1: an internal start-of-frame lasts a single bit clock
  p_sof_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && sh_internal) |=> !sof);

  // R5: the first cycle of a run carries sof and the active level
  p_first_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (sof && (!fs_oe || (fs_out != sh_fall))));

  // R3: a one-bit pulse is back at the idle level one cycle after it starts
  p_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && sh_internal && !sh_wide) |=> (!fs_oe || (fs_out == sh_fall)));

  // R8: inside a running frame the shadowed settings hold
  p_cfg_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !sof) |-> ($stable(sh_slots) && $stable(sh_fall) && $stable(sh_wide)));

  // R2: the shadowed slot count is always in the legal range
  p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_slots >= SLOT_W'(MIN_SLOTS)) && (sh_slots <= SLOT_W'(MAX_SLOTS)));
endmodule

bind tdm_fsync_gen tdm_fsync_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_dir_out (pin_dir_out),
  .fs_out      (fs_out),
  .fs_oe       (fs_oe),
  .sof         (sof),
  .run_q       (run_q),
  .sh_internal (sh_q.internal),
  .sh_fall     (sh_q.fall),
  .sh_wide     (sh_q.wide),
  .sh_slots    (sh_q.slots)
);

// File: tb/tdm_fsync_gen_tb.sv
module tdm_fsync_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WL         = 4;
  localparam int SW         = tdm_fsync_pkg::SLOT_W;

  logic          clk = 1'b0;
  logic          rst_n, enable, cfg_wide, cfg_fall, cfg_internal, pin_dir_out, fs_in;
  logic [SW-1:0] cfg_slots;
  logic          fs_out, fs_oe, sof;
  int            errors = 0;
  int            checks = 0;
  bit            done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_fsync_gen #(.WORD_LEN(WL), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_slots(cfg_slots),
    .cfg_wide(cfg_wide), .cfg_fall(cfg_fall), .cfg_internal(cfg_internal),
    .pin_dir_out(pin_dir_out), .fs_in(fs_in), .fs_out(fs_out), .fs_oe(fs_oe), .sof(sof)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Two full frames of one configuration, checked bit clock by bit clock
  task automatic run_frames(input int slots_in, input int exp_slots, input int wide,
                            input int fall, input string req);
    int frame_len, pos, act;
    @(negedge clk);
    enable = 1'b0; cfg_slots = SW'(slots_in); cfg_wide = wide[0]; cfg_fall = fall[0];
    cfg_internal = 1'b1; pin_dir_out = 1'b1;
    @(negedge clk);
    chk({req, " R4 idle level"}, fs_out, fall);
    chk({req, " R5 idle sof"}, sof, 0);
    enable = 1'b1;
    frame_len = exp_slots * WL;
    for (int t = 0; t < 2 * frame_len; t++) begin
      @(negedge clk);
      pos = t % frame_len;
      act = wide ? int'(pos < WL) : int'(pos == 0);
      chk({req, " R3 R4 pulse"}, fs_out, act ^ fall);
      chk({req, " R1 sof"}, sof, int'(pos == 0));
    end
    enable = 1'b0;
    @(negedge clk);
    chk({req, " R5 back to idle"}, fs_out, fall);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int pos;
    rst_n = 1'b0; enable = 1'b0; cfg_slots = SW'(2); cfg_wide = 1'b0; cfg_fall = 1'b0;
    cfg_internal = 1'b1; pin_dir_out = 1'b0; fs_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset fs_oe", fs_oe, 0);
    chk("R9 reset fs_out", fs_out, 0);
    chk("R9 reset sof", sof, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 after release fs_oe", fs_oe, 0);
    chk("R9 after release sof", sof, 0);

    // R1 R3 R4: sweep of every legal slot count, width and polarity
    for (int s = 2; s <= 32; s++)
      for (int w = 0; w < 2; w++)
        for (int f = 0; f < 2; f++)
          run_frames(s, s, w, f, "sweep");

    // R2: out-of-range slot settings
    run_frames(0, 2, 0, 0, "R2 zero");
    run_frames(1, 2, 1, 1, "R2 one");
    run_frames(33, 32, 0, 1, "R2 33");
    run_frames(63, 32, 1, 0, "R2 63");

    // R5: a one-cycle disable mid-frame restarts the frame at once
    @(negedge clk);
    cfg_slots = SW'(3); cfg_wide = 1'b0; cfg_fall = 1'b0; cfg_internal = 1'b1;
    pin_dir_out = 1'b1; enable = 1'b1;
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R5 disabled fs_out", fs_out, 0);
    chk("R5 disabled sof", sof, 0);
    enable = 1'b1;
    @(negedge clk);
    chk("R5 first sof", sof, 1);
    chk("R5 first pulse", fs_out, 1);
    @(negedge clk);
    chk("R5 second bit", fs_out, 0);
    enable = 1'b0;

    // R8: change slots and polarity at bit 2 of a 3-slot frame
    @(negedge clk);
    cfg_slots = SW'(3); cfg_wide = 1'b0; cfg_fall = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (t < 12) begin
        chk("R8 old frame pulse", fs_out, int'(t == 0));
        chk("R8 old frame sof", sof, int'(t == 0));
      end else begin
        pos = (t - 12) % 20;
        chk("R8 new frame pulse", fs_out, int'(pos == 0) ^ 1);
        chk("R8 new frame sof", sof, int'(pos == 0));
      end
      if (t == 2) begin
        cfg_slots = SW'(5); cfg_fall = 1'b1;
      end
    end
    enable = 1'b0;

    // R7: direction control gates the pin
    @(negedge clk);
    pin_dir_out = 1'b0; cfg_slots = SW'(2); cfg_wide = 1'b1; cfg_fall = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      chk("R7 undriven fs_oe", fs_oe, 0);
      chk("R7 undriven fs_out", fs_out, 0);
    end
    pin_dir_out = 1'b1;
    @(negedge clk);
    chk("R7 driven fs_oe", fs_oe, 1);
    chk("R7 driven active low", fs_out, 0);
    repeat (4) @(negedge clk);
    chk("R7 driven idle high", fs_out, 1);
    enable = 1'b0;

    // R6: external source, rising edge selected
    @(negedge clk);
    cfg_internal = 1'b0; cfg_fall = 1'b0; pin_dir_out = 1'b1; fs_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 external never drives", fs_oe, 0);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 quiet", sof, 0);
    fs_in = 1'b1;
    @(negedge clk); chk("R6 rise stage 1", sof, 0);
    @(negedge clk); chk("R6 rise detect", sof, 1);
    @(negedge clk); chk("R6 rise one cycle", sof, 0);
    repeat (2) @(negedge clk);
    fs_in = 1'b0;
    for (int t = 0; t < 5; t++) begin
      @(negedge clk);
      chk("R6 falling ignored", sof, 0);
    end

    // R6: falling edge selected
    enable = 1'b0; cfg_fall = 1'b1;
    @(negedge clk);
    enable = 1'b1; fs_in = 1'b1;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      chk("R6 rising ignored", sof, 0);
    end
    fs_in = 1'b0;
    @(negedge clk); chk("R6 fall stage 1", sof, 0);
    @(negedge clk); chk("R6 fall detect", sof, 1);
    @(negedge clk); chk("R6 fall one cycle", sof, 0);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule